// File: doc/BRIEF.md
# Dual Countdown Timer Pair

This block keeps two 8-bit down-counters for a small game-console style virtual machine: a delay counter that software polls and a sound counter whose only visible effect is a tone-enable output. Both counters are updated on the same periodic tick. The tick comes from an internal prescaler that divides the system clock. A software-selectable timing model decides both the tick period and the amount subtracted per tick. The modern model is a fast tick with a step of one. The legacy model is a slower tick with a step of three.

A counter that is already zero is left alone. A step larger than the remaining value parks the counter at exactly zero, so the count never wraps. Either counter can be loaded at any time. A load wins over a tick that falls in the same cycle. Changing the timing model restarts the prescaler, so the first tick under the new model comes one full new period after the change.

Top module: `cdt_pair`

## Requirements
- R1: After reset both counters are zero, `snd_active` is low and the timing model is modern (`mode_legacy_out` = 0).
- R2: In the modern model (`mode_legacy_out` = 0), each tick lowers every non-zero counter by 1.
- R3: In the legacy model (`mode_legacy_out` = 1), each tick lowers every counter that holds 3 or more by 3.
- R4: A counter below the step on a tick becomes exactly 0, and a counter at 0 stays at 0 on every later tick.
- R5: `tick_out` is high for one cycle in every DIV_MODERN cycles in the modern model and every DIV_LEGACY cycles in the legacy model.
- R6: A write through `mode_we` that changes the model (`mode_legacy_in` 1 = legacy, 0 = modern) restarts the prescaler. The next tick is seen DIV cycles of the new model after the write cycle, and the write cycle itself produces no tick.
- R7: A load through `dly_we` or `snd_we` is visible in the next cycle. If a tick occurs in the same cycle, the load wins.
- R8: `snd_active` is high exactly while the sound counter is non-zero.
- R9: Loading one counter leaves the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Strobe that loads the timing model |
| mode_legacy_in | input | 1 | Model to load: 1 legacy, 0 modern |
| dly_we | input | 1 | Load strobe for the delay counter |
| dly_wdata | input | CNT_W | Value loaded into the delay counter |
| snd_we | input | 1 | Load strobe for the sound counter |
| snd_wdata | input | CNT_W | Value loaded into the sound counter |
| dly_value | output | CNT_W | Current delay counter value |
| snd_active | output | 1 | High while the sound counter is non-zero |
| mode_legacy_out | output | 1 | Current timing model: 1 legacy, 0 modern |
| tick_out | output | 1 | Prescaler tick strobe |

## Verification
The hardest case to reach from the ports is a load that lands exactly on a tick. The tick phase is internal to the block. The stimulus therefore watches `tick_out` at the falling edge and issues the load while the strobe is high, so the load and the tick take effect on the same rising edge. The same watching keeps ordinary loads off tick cycles, so the expected counter values stay exact. The prescaler restart is measured by counting cycles from the model-change write to the next strobe.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic {
    MODE_MODERN = 1'b0,
    MODE_LEGACY = 1'b1
  } cdt_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_DLY = 0;
  localparam int unsigned CH_SND = 1;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int unsigned DIV_MODERN = 4166667,
  parameter int unsigned DIV_LEGACY = 13736264
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cdt_mode_e mode,
  input  logic      restart,
  output logic      tick
);
  localparam int unsigned DIV_MAX = (DIV_MODERN > DIV_LEGACY) ? DIV_MODERN : DIV_LEGACY;
  localparam int unsigned CW      = $clog2(DIV_MAX);
  localparam logic [CW-1:0] LIM_MODERN = CW'(DIV_MODERN - 1);
  localparam logic [CW-1:0] LIM_LEGACY = CW'(DIV_LEGACY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic          at_limit;

  always_comb begin
    limit    = (mode == MODE_LEGACY) ? LIM_LEGACY : LIM_MODERN;
    at_limit = (cnt_q >= limit);
    if (restart || at_limit) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_limit && !restart;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned STEP_MODERN = 1,
  parameter int unsigned STEP_LEGACY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  cdt_mode_e    mode,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] STEP_M = W'(STEP_MODERN);
  localparam logic [W-1:0] STEP_L = W'(STEP_LEGACY);

  logic [W-1:0] value_q, value_d;
  logic [W-1:0] step;
  logic         nonzero;
  logic         upd_en;

  always_comb begin
    step    = (mode == MODE_LEGACY) ? STEP_L : STEP_M;
    nonzero = (value_q != '0);
    upd_en  = we || (tick && nonzero);
    if (we)                  value_d = wdata;
    else if (value_q > step) value_d = value_q - step;
    else                     value_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_q <= '0;
    else if (upd_en) value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/cdt_pair.sv
module cdt_pair
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned DIV_MODERN  = 4166667,
  parameter int unsigned DIV_LEGACY  = 13736264,
  parameter int unsigned STEP_MODERN = 1,
  parameter int unsigned STEP_LEGACY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic             mode_legacy_in,
  input  logic             dly_we,
  input  logic [CNT_W-1:0] dly_wdata,
  input  logic             snd_we,
  input  logic [CNT_W-1:0] snd_wdata,
  output logic [CNT_W-1:0] dly_value,
  output logic             snd_active,
  output logic             mode_legacy_out,
  output logic             tick_out
);
  logic      rst_sync_n;
  cdt_mode_e mode_q, mode_d;
  logic      mode_chg;
  logic      tick;

  logic             ch_we    [NUM_CH];
  logic [CNT_W-1:0] ch_wdata [NUM_CH];
  logic [CNT_W-1:0] ch_value [NUM_CH];

  cdt_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  always_comb begin
    mode_d   = mode_legacy_in ? MODE_LEGACY : MODE_MODERN;
    mode_chg = mode_we && (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   mode_q <= MODE_MODERN;
    else if (mode_chg) mode_q <= mode_d;
  end

  cdt_prescaler #(
    .DIV_MODERN (DIV_MODERN),
    .DIV_LEGACY (DIV_LEGACY)
  ) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode    (mode_q),
    .restart (mode_chg),
    .tick    (tick)
  );

  assign ch_we[CH_DLY]    = dly_we;
  assign ch_wdata[CH_DLY] = dly_wdata;
  assign ch_we[CH_SND]    = snd_we;
  assign ch_wdata[CH_SND] = snd_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cdt_timer #(
      .W           (CNT_W),
      .STEP_MODERN (STEP_MODERN),
      .STEP_LEGACY (STEP_LEGACY)
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tick  (tick),
      .mode  (mode_q),
      .we    (ch_we[g]),
      .wdata (ch_wdata[g]),
      .value (ch_value[g])
    );
  end

  assign dly_value       = ch_value[CH_DLY];
  assign snd_active      = (ch_value[CH_SND] != '0);
  assign mode_legacy_out = (mode_q == MODE_LEGACY);
  assign tick_out        = tick;
endmodule

// File: rtl/cdt_pair_chk.sv
module cdt_pair_chk #(
  parameter int unsigned W           = 8,
  parameter int unsigned STEP_MODERN = 1,
  parameter int unsigned STEP_LEGACY = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         legacy,
  input logic         mode_chg,
  input logic         dly_we,
  input logic [W-1:0] dly_wdata,
  input logic [W-1:0] dly_value,
  input logic         snd_we,
  input logic [W-1:0] snd_wdata,
  input logic         snd_active
);
  localparam logic [W-1:0] SM = W'(STEP_MODERN);
  localparam logic [W-1:0] SL = W'(STEP_LEGACY);

  // R2: modern step
  p_modern_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !legacy && !dly_we && dly_value > SM) |=> (dly_value == W'($past(dly_value) - SM)));

  // R3: legacy step
  p_legacy_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && legacy && !dly_we && dly_value > SL) |=> (dly_value == W'($past(dly_value) - SL)));

  // R4: clamp at zero in the legacy model
  p_clamp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && legacy && !dly_we && dly_value <= SL) |=> (dly_value == '0));

  // R7: load wins and is visible next cycle
  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dly_we |=> (dly_value == $past(dly_wdata)));

  // R7: no load and no tick keeps the value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !dly_we) |=> $stable(dly_value));

  // R8: loading zero silences the sound output
  p_snd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_we && snd_wdata == '0) |=> !snd_active);

  // R5: tick lasts a single cycle
  p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6: a model change restarts the prescaler
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !tick);
endmodule

bind cdt_pair cdt_pair_chk #(
  .W           (CNT_W),
  .STEP_MODERN (STEP_MODERN),
  .STEP_LEGACY (STEP_LEGACY)
) u_cdt_pair_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick_out),
  .legacy     (mode_legacy_out),
  .mode_chg   (mode_chg),
  .dly_we     (dly_we),
  .dly_wdata  (dly_wdata),
  .dly_value  (dly_value),
  .snd_we     (snd_we),
  .snd_wdata  (snd_wdata),
  .snd_active (snd_active)
);

// File: tb/test_cdt_pair.sv
`timescale 1ns/1ps
module test_cdt_pair;
  localparam int W     = 8;
  localparam int DIV_M = 4;
  localparam int DIV_L = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_we, mode_legacy_in;
  logic         dly_we, snd_we;
  logic [W-1:0] dly_wdata, snd_wdata;
  logic [W-1:0] dly_value;
  logic         snd_active, mode_legacy_out, tick_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  cdt_pair #(
    .CNT_W      (W),
    .DIV_MODERN (DIV_M),
    .DIV_LEGACY (DIV_L)
  ) i_cdt_pair (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_we         (mode_we),
    .mode_legacy_in  (mode_legacy_in),
    .dly_we          (dly_we),
    .dly_wdata       (dly_wdata),
    .snd_we          (snd_we),
    .snd_wdata       (snd_wdata),
    .dly_value       (dly_value),
    .snd_active      (snd_active),
    .mode_legacy_out (mode_legacy_out),
    .tick_out        (tick_out)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] exp_dly;
    bit           exp_act;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;

  task automatic expect_out(input string tag, input logic [W-1:0] d, input bit a);
    sb_item_t it;
    it.tag = tag; it.exp_dly = d; it.exp_act = a;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        total++;
        if (dly_value !== it.exp_dly || snd_active !== it.exp_act) begin
          bad++;
          $display("FAIL %s: dly=%0d act=%0b expected dly=%0d act=%0b",
                   it.tag, dly_value, snd_active, it.exp_dly, it.exp_act);
        end
      end
    end
  end

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    int guard = 0;
    while (!tick_out && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic load(input bit snd, input logic [W-1:0] v);
    while (tick_out) @(negedge clk);
    if (snd) begin snd_we = 1'b1; snd_wdata = v; end
    else     begin dly_we = 1'b1; dly_wdata = v; end
    @(negedge clk);
    snd_we = 1'b0; dly_we = 1'b0;
  endtask

  task automatic measure_period(output int n);
    n = 1;
    while (!tick_out && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_mode(input bit leg, output int n);
    mode_we = 1'b1; mode_legacy_in = leg;
    @(negedge clk);
    mode_we = 1'b0;
    measure_period(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; mode_we = 0; mode_legacy_in = 0;
    dly_we = 0; snd_we = 0; dly_wdata = '0; snd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_out("R1 reset", 8'd0, 1'b0);
    check_int("R1 mode after reset", int'(mode_legacy_out), 0);

    // R5 modern period
    wait_tick();
    measure_period(n);
    check_int("R5 modern period", n, DIV_M);

    // R7 load coinciding with a tick
    while (!tick_out) @(negedge clk);
    dly_we = 1; dly_wdata = 8'd20; snd_we = 1; snd_wdata = 8'd5;
    @(negedge clk);
    dly_we = 0; snd_we = 0;
    expect_out("R7 load wins over tick", 8'd20, 1'b1);

    // R2 modern step
    wait_tick();
    expect_out("R2 modern step", 8'd19, 1'b1);

    // R9 and R8: clear sound only
    load(1'b1, 8'd0);
    expect_out("R9 delay untouched by sound load", 8'd19, 1'b0);

    // R8 sound active follows the sound counter
    load(1'b1, 8'd2);
    expect_out("R8 sound active after load", 8'd19, 1'b1);
    wait_tick();
    expect_out("R8 sound still active", 8'd18, 1'b1);
    wait_tick();
    expect_out("R8 sound reaches zero", 8'd17, 1'b0);

    // R6 switch to legacy restarts the prescaler
    set_mode(1'b1, n);
    check_int("R6 restart to legacy", n, DIV_L);
    check_int("R3 mode readback", int'(mode_legacy_out), 1);
    wait_tick();
    measure_period(n);
    check_int("R5 legacy period", n, DIV_L);

    // R3 / R4 legacy steps and clamp
    load(1'b0, 8'd10);
    load(1'b1, 8'd2);
    expect_out("R9 both loaded", 8'd10, 1'b1);
    wait_tick();
    expect_out("R3 legacy step, R4 sound clamp", 8'd7, 1'b0);
    wait_tick();
    expect_out("R3 legacy step", 8'd4, 1'b0);
    wait_tick();
    expect_out("R3 legacy step", 8'd1, 1'b0);
    wait_tick();
    expect_out("R4 clamp to zero", 8'd0, 1'b0);
    wait_tick();
    expect_out("R4 zero stays zero", 8'd0, 1'b0);

    // R6 back to modern
    set_mode(1'b0, n);
    check_int("R6 restart to modern", n, DIV_M);
    load(1'b0, 8'd1);
    wait_tick();
    expect_out("R2 modern step to zero", 8'd0, 1'b0);
    wait_tick();
    expect_out("R4 modern zero holds", 8'd0, 1'b0);

    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule